// File: doc/BRIEF.md
# Latency-Configurable RAM Channel Adapter

This block sits between four valid/ready streaming channels and the pins of a synchronous RAM with one read port and one write port. Read and write each have a request channel and a response channel. A read request addresses the RAM at once. The returned word is taken from the RAM's read data bus a fixed number of cycles later, set by the `LAT` parameter, and queued for the read-response channel. A write request drives the write strobe, address and data in the cycle of its handshake. One cycle later it produces a write acknowledgement, which is held until it is taken.

A credit counter bounds the reads in flight plus the responses waiting. A stalled response consumer therefore stops further read issue and no captured word is lost. The block keeps a write-then-read order. Writes take priority. A read is accepted only once no write request is offered and no write acknowledgement is still waiting to be delivered. As a result, a read that follows a write reaches the RAM at least one cycle after that write's acknowledgement has been handed over. A latency below one, or a response queue shallower than `LAT+1`, stops elaboration.

Top module: `ramch_adapter`

## Requirements
- R1: A read accepted in cycle t takes its word from `ram_rd_data` during cycle t+LAT, and presents it on `rd_resp_valid`/`rd_resp_data` from cycle t+LAT+1 onward. When the response queue is already empty, it appears exactly in cycle t+LAT+1.
- R2: `ram_rd_en` is high exactly in the cycles where a read-request handshake occurs, with `ram_rd_addr` equal to `rd_req_addr` in that cycle. No other cycle carries a read strobe.
- R3: With `rd_resp_ready` held high and no write activity, a read request is accepted in every cycle.
- R4: Reads accepted but not yet delivered never exceed DEPTH. A response delivered in the same cycle frees its place. While `rd_resp_ready` is low, the head response and its data stay unchanged. Starting from empty, exactly DEPTH reads are accepted during a long stall.
- R5: Read responses are delivered in the order their requests were accepted, each carrying the RAM contents as left by all writes accepted before it.
- R6: A write handshake drives `ram_wr_en` with `ram_wr_addr`/`ram_wr_data` equal to the request in the same cycle. `wr_resp_valid` rises in the next cycle and stays high until `wr_resp_ready`. At most one acknowledgement is pending: `wr_req_ready` equals (no acknowledgement pending) or `wr_resp_ready`.
- R7: `rd_req_ready` is low while `wr_req_valid` is high or a write acknowledgement is pending. A write followed by a read with both offered together and the acknowledgement taken at once puts the read strobe exactly two cycles after the write strobe.
- R8: A synchronous active-high `rst` drops all in-flight reads, queued responses and the pending acknowledgement. After it, `ram_rd_en`, `ram_wr_en`, `rd_resp_valid` and `wr_resp_valid` are low and `rd_req_ready` is high when no write is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request accepted |
| rd_req_addr | input | AW | Read address |
| rd_resp_valid | output | 1 | Read word available |
| rd_resp_ready | input | 1 | Consumer takes read word |
| rd_resp_data | output | DW | Read word |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write request accepted |
| wr_req_addr | input | AW | Write address |
| wr_req_data | input | DW | Write data |
| wr_resp_valid | output | 1 | Write acknowledgement pending |
| wr_resp_ready | input | 1 | Acknowledgement taken |
| ram_rd_en | output | 1 | RAM read strobe |
| ram_rd_addr | output | AW | RAM read address |
| ram_rd_data | input | DW | RAM read data bus |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | AW | RAM write address |
| ram_wr_data | output | DW | RAM write data |

## Verification
A back-to-back read burst with a free consumer checks the one-per-cycle rate and the exact arrival cycle. A RAM model that puts a filler value on its data bus outside valid slots makes any capture one cycle early or late show up as wrong data. A long consumer stall from an empty state tells a correct credit limit apart from overflow or early blocking. A write and a read to the same address offered together tell write-then-read ordering apart from a simultaneous or reversed issue. A long random mix of valid and ready patterns, followed by a reset with reads in flight, exercises the remaining interleavings against the cycle model.

// File: rtl/ramch_pkg.sv
`timescale 1ns/1ps
package ramch_pkg;
   function automatic int unsigned ptr_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
   function automatic int unsigned cnt_bits(input int unsigned n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/ramch_rd_track.sv
`timescale 1ns/1ps
module ramch_rd_track #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic issue,
   output logic capture
);
   logic [LAT-1:0] stage;

   generate
      if (LAT == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= issue;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (rst) stage <= '0;
            else     stage <= {stage[LAT-2:0], issue};
         end
      end
   endgenerate

   assign capture = stage[LAT-1];

   assert_first_stage_R1: assert property (@(posedge clk) disable iff (rst)
      issue |=> stage[0]);
endmodule

// File: rtl/ramch_resp_fifo.sv
`timescale 1ns/1ps
module ramch_resp_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);
   localparam int PW = ramch_pkg::ptr_bits(DEPTH);
   localparam int CW = ramch_pkg::cnt_bits(DEPTH);
   localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULLC = CW'(DEPTH);

   logic [DW-1:0] slots [DEPTH];
   logic [PW-1:0] wp, rp;
   logic [CW-1:0] cnt;
   logic          pop;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == LAST) ? '0 : p + 1'b1;
   endfunction

   assign pop       = out_valid && out_ready;
   assign out_valid = (cnt != '0);
   assign out_data  = slots[rp];

   always_ff @(posedge clk) begin
      if (rst) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= step(wp);
         if (pop)  rp <= step(rp);
         cnt <= cnt + CW'(push) - CW'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) slots[wp] <= push_data;
   end

   assert_fifo_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
      push |-> (cnt != FULLC) || pop);
   assert_resp_hold_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
endmodule

// File: rtl/ramch_wr_ctrl.sv
`timescale 1ns/1ps
module ramch_wr_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic req_valid,
   output logic req_ready,
   output logic fire,
   output logic resp_valid,
   input  logic resp_ready
);
   logic pend;

   assign req_ready  = !pend || resp_ready;
   assign fire       = req_valid && req_ready;
   assign resp_valid = pend;

   always_ff @(posedge clk) begin
      if (rst)             pend <= 1'b0;
      else if (fire)       pend <= 1'b1;
      else if (resp_ready) pend <= 1'b0;
   end

   assert_wr_resp_next_R6: assert property (@(posedge clk) disable iff (rst)
      fire |=> resp_valid);
   assert_wr_resp_hold_R6: assert property (@(posedge clk) disable iff (rst)
      resp_valid && !resp_ready |=> resp_valid);
endmodule

// File: rtl/ramch_adapter.sv
`timescale 1ns/1ps
module ramch_adapter #(
   parameter int AW    = 8,
   parameter int DW    = 8,
   parameter int LAT   = 2,
   parameter int DEPTH = LAT + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rd_req_valid,
   output logic          rd_req_ready,
   input  logic [AW-1:0] rd_req_addr,
   output logic          rd_resp_valid,
   input  logic          rd_resp_ready,
   output logic [DW-1:0] rd_resp_data,
   input  logic          wr_req_valid,
   output logic          wr_req_ready,
   input  logic [AW-1:0] wr_req_addr,
   input  logic [DW-1:0] wr_req_data,
   output logic          wr_resp_valid,
   input  logic          wr_resp_ready,
   output logic          ram_rd_en,
   output logic [AW-1:0] ram_rd_addr,
   input  logic [DW-1:0] ram_rd_data,
   output logic          ram_wr_en,
   output logic [AW-1:0] ram_wr_addr,
   output logic [DW-1:0] ram_wr_data
);
   localparam int CW = ramch_pkg::cnt_bits(DEPTH);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("ramch_adapter: LAT must be at least 1");
      end
      if (DEPTH < LAT + 1) begin : g_bad_depth
         $error("ramch_adapter: DEPTH must be at least LAT+1");
      end
   endgenerate

   logic          rd_fire, wr_fire, capture, pop;
   logic [CW-1:0] owed;

   ramch_wr_ctrl u_wr (
      .clk        (clk),
      .rst        (rst),
      .req_valid  (wr_req_valid),
      .req_ready  (wr_req_ready),
      .fire       (wr_fire),
      .resp_valid (wr_resp_valid),
      .resp_ready (wr_resp_ready)
   );

   assign pop          = rd_resp_valid && rd_resp_ready;
   assign rd_req_ready = !wr_resp_valid && !wr_req_valid &&
                         ((owed != DEPTH_C) || pop);
   assign rd_fire      = rd_req_valid && rd_req_ready;

   assign ram_rd_en   = rd_fire;
   assign ram_rd_addr = rd_req_addr;
   assign ram_wr_en   = wr_fire;
   assign ram_wr_addr = wr_req_addr;
   assign ram_wr_data = wr_req_data;

   always_ff @(posedge clk) begin
      if (rst) owed <= '0;
      else     owed <= owed + CW'(rd_fire) - CW'(pop);
   end

   ramch_rd_track #(.LAT(LAT)) u_track (
      .clk     (clk),
      .rst     (rst),
      .issue   (rd_fire),
      .capture (capture)
   );

   ramch_resp_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst       (rst),
      .push      (capture),
      .push_data (ram_rd_data),
      .out_valid (rd_resp_valid),
      .out_ready (rd_resp_ready),
      .out_data  (rd_resp_data)
   );

   assert_credit_bound_R4: assert property (@(posedge clk) disable iff (rst)
      owed <= DEPTH_C);
   assert_rd_after_wr_R7: assert property (@(posedge clk) disable iff (rst)
      ram_rd_en |-> !ram_wr_en && !wr_resp_valid);
   assert_reset_idle_R8: assert property (@(posedge clk)
      rst |=> !rd_resp_valid && !wr_resp_valid);
   assert_strobe_once_R2: assert property (@(posedge clk) disable iff (rst)
      !(ram_rd_en && ram_wr_en));
endmodule

// File: tb/ramch_adapter_tb.sv
`timescale 1ns/1ps
module ramch_adapter_tb;
   localparam int AW = 8, DW = 8, LAT = 2, DEPTH = LAT + 1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rd_req_valid = 0, rd_resp_ready = 0, wr_req_valid = 0, wr_resp_ready = 0;
   logic [AW-1:0] rd_req_addr = '0, wr_req_addr = '0;
   logic [DW-1:0] wr_req_data = '0;
   logic rd_req_ready, rd_resp_valid, wr_req_ready, wr_resp_valid;
   logic [DW-1:0] rd_resp_data, ram_rd_data, ram_wr_data;
   logic ram_rd_en, ram_wr_en;
   logic [AW-1:0] ram_rd_addr, ram_wr_addr;

   always #2.5 clk = ~clk;

   ramch_adapter #(.AW(AW), .DW(DW), .LAT(LAT), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst(rst),
      .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
      .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready), .rd_resp_data(rd_resp_data),
      .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
      .wr_req_data(wr_req_data), .wr_resp_valid(wr_resp_valid), .wr_resp_ready(wr_resp_ready),
      .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
      .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data)
   );

   // RAM model: LAT-cycle read pipeline, filler value in empty slots
   logic [DW-1:0] ram_mem [256];
   logic [DW-1:0] rpipe [LAT];
   assign ram_rd_data = rpipe[LAT-1];
   always @(posedge clk) begin
      if (ram_wr_en) ram_mem[ram_wr_addr] <= ram_wr_data;
      rpipe[0] <= ram_rd_en ? ram_mem[ram_rd_addr] : 8'hEE;
      for (int i = 1; i < LAT; i++) rpipe[i] <= rpipe[i-1];
   end

   int checks = 0, errors = 0, cyc = 0;
   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // behavioural reference model
   logic [DW-1:0] m_mem [256];
   int q_d[$], q_a[$];
   bit m_wpend = 0;
   int rd_fires = 0, last_wr_cyc = -1, last_rd_cyc = -1;
   bit e_rvalid, e_pop, e_wready, e_wfire, e_rready, e_rfire;

   initial begin
      for (int i = 0; i < 256; i++) begin
         ram_mem[i] = 8'(i ^ 8'h5A);
         m_mem[i]   = 8'(i ^ 8'h5A);
      end
      for (int i = 0; i < LAT; i++) rpipe[i] = 8'hEE;
   end

   always @(negedge clk) begin
      cyc++;
      if (rst) begin
         q_d.delete(); q_a.delete(); m_wpend = 0;
      end else begin
         e_rvalid = (q_d.size() > 0) && (q_a[0] <= cyc);
         e_pop    = e_rvalid && rd_resp_ready;
         e_wready = !m_wpend || wr_resp_ready;
         e_wfire  = wr_req_valid && e_wready;
         e_rready = !m_wpend && !wr_req_valid && ((q_d.size() - int'(e_pop)) < DEPTH);
         e_rfire  = rd_req_valid && e_rready;
         chk(rd_req_ready == e_rready, "R4,R7", "rd_req_ready", rd_req_ready, e_rready);
         chk(ram_rd_en == e_rfire, "R2", "ram_rd_en", ram_rd_en, e_rfire);
         if (e_rfire) chk(ram_rd_addr == rd_req_addr, "R2", "ram_rd_addr", ram_rd_addr, rd_req_addr);
         chk(wr_req_ready == e_wready, "R6", "wr_req_ready", wr_req_ready, e_wready);
         chk(ram_wr_en == e_wfire, "R6", "ram_wr_en", ram_wr_en, e_wfire);
         if (e_wfire) begin
            chk(ram_wr_addr == wr_req_addr, "R6", "ram_wr_addr", ram_wr_addr, wr_req_addr);
            chk(ram_wr_data == wr_req_data, "R6", "ram_wr_data", ram_wr_data, wr_req_data);
         end
         chk(wr_resp_valid == m_wpend, "R6", "wr_resp_valid", wr_resp_valid, m_wpend);
         chk(rd_resp_valid == e_rvalid, "R1", "rd_resp_valid", rd_resp_valid, e_rvalid);
         if (e_rvalid) chk(rd_resp_data == 8'(q_d[0]), "R1,R5", "rd_resp_data", rd_resp_data, q_d[0]);
         if (e_pop) begin void'(q_d.pop_front()); void'(q_a.pop_front()); end
         if (e_rfire) begin
            q_d.push_back(int'(m_mem[rd_req_addr]));
            q_a.push_back(cyc + LAT + 1);
            rd_fires++;
            last_rd_cyc = cyc;
         end
         if (e_wfire) begin
            m_mem[wr_req_addr] = wr_req_data;
            last_wr_cyc = cyc;
         end
         if (e_wfire) m_wpend = 1;
         else if (wr_resp_ready) m_wpend = 0;
      end
   end

   // watchdog
   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         chk(0, "WD", "watchdog expired", wd, 150000);
         finish_run();
      end
   end

   task automatic rd_one(input logic [AW-1:0] a, output int waited);
      bit hs;
      rd_req_valid = 1; rd_req_addr = a; waited = 0;
      do begin
         @(negedge clk); hs = rd_req_ready; waited++;
         @(posedge clk); #1;
      end while (!hs && waited < 200);
   endtask

   task automatic wr_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bit hs; int n = 0;
      wr_req_valid = 1; wr_req_addr = a; wr_req_data = d;
      do begin
         @(negedge clk); hs = wr_req_ready; n++;
         @(posedge clk); #1;
      end while (!hs && n < 200);
      wr_req_valid = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      int w, total, f0;
      repeat (3) @(posedge clk);
      #1 rst = 0;
      @(negedge clk);
      // R8: idle after reset
      chk(!rd_resp_valid && !wr_resp_valid, "R8", "resp valids after reset", {rd_resp_valid, wr_resp_valid}, 0);
      chk(!ram_rd_en && !ram_wr_en, "R8", "strobes after reset", {ram_rd_en, ram_wr_en}, 0);
      chk(rd_req_ready == 1, "R8", "rd_req_ready after reset", rd_req_ready, 1);
      @(posedge clk); #1;

      // writes, acknowledgements taken at once
      wr_resp_ready = 1; rd_resp_ready = 1;
      for (int a = 0; a < 16; a++) wr_one(8'(a), 8'(a * 7 + 3));
      idle(2);

      // R3: back-to-back reads
      total = 0;
      for (int a = 0; a < 16; a++) begin rd_one(8'(a), w); total += w; end
      rd_req_valid = 0;
      chk(total == 16, "R3", "cycles for 16 reads", total, 16);
      idle(10);

      // R4: stall from empty accepts exactly DEPTH reads
      rd_resp_ready = 0; f0 = rd_fires;
      rd_req_valid = 1;
      for (int i = 0; i < 12; i++) begin rd_req_addr = 8'(20 + i); idle(1); end
      rd_req_valid = 0;
      chk(rd_fires - f0 == DEPTH, "R4", "reads accepted during stall", rd_fires - f0, DEPTH);
      rd_resp_ready = 1; idle(10);

      // R7: write and read to the same address offered together
      fork
         wr_one(8'd5, 8'hA5);
         rd_one(8'd5, w);
      join
      rd_req_valid = 0;
      chk(last_rd_cyc == last_wr_cyc + 2, "R7", "read strobe cycle", last_rd_cyc, last_wr_cyc + 2);
      idle(8);

      // R6: held acknowledgement blocks second write
      wr_resp_ready = 0;
      wr_one(8'd9, 8'h33);
      wr_req_valid = 1; wr_req_addr = 8'd10; wr_req_data = 8'h44;
      idle(3);
      @(negedge clk);
      chk(wr_resp_valid == 1, "R6", "ack held", wr_resp_valid, 1);
      chk(wr_req_ready == 0, "R6", "second write blocked", wr_req_ready, 0);
      @(posedge clk); #1;
      wr_resp_ready = 1; idle(1);
      wr_req_valid = 0; idle(4);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         rd_req_valid  = 1'($urandom % 2);
         rd_req_addr   = 8'($urandom % 16);
         wr_req_valid  = ($urandom % 4) == 0;
         wr_req_addr   = 8'($urandom % 16);
         wr_req_data   = 8'($urandom);
         rd_resp_ready = ($urandom % 4) != 0;
         wr_resp_ready = 1'($urandom % 2);
         idle(1);
      end
      wr_req_valid = 0; rd_req_valid = 1; rd_resp_ready = 0; wr_resp_ready = 1;
      idle(4);

      // R8: reset with reads in flight
      rd_req_valid = 0; rst = 1;
      idle(2);
      rst = 0;
      @(negedge clk);
      chk(!rd_resp_valid && !wr_resp_valid, "R8", "resp valids after mid reset", {rd_resp_valid, wr_resp_valid}, 0);
      chk(rd_req_ready == 1, "R8", "credit cleared", rd_req_ready, 1);
      @(posedge clk); #1;
      rd_resp_ready = 1;
      idle(10);
      finish_run();
   end
endmodule